// File: doc/BRIEF.md
# Zero-Address Stack Processor Core

This block is a small multi-cycle processor whose arithmetic works only on an internal hardware operand stack. It fetches instructions of one or four bytes through a single byte-wide synchronous memory port that also serves data accesses. A program counter gives the address of each instruction. Transfer instructions name one 24-bit memory address. Arithmetic instructions name none: they consume the two topmost stack entries and leave a single result on top.

Data words are 32 bits, kept big-endian in byte-addressed memory. The stack holds 16 words. The core stops on a halt instruction, or on any illegal condition, which also raises a sticky fault flag. A program is loaded into memory while reset is held. Once the core has halted, its results are read from memory.

Top module: `stk_core`

## Requirements
- R1: While reset is asserted and right after it, the program counter is 0 and the stack is empty. `fault` and `halted` are low, and the first fetch reads byte address 0.
- R2: Opcodes are one byte: 0x01 load-to-stack, 0x02 store-from-stack, 0x10 add, 0x11 sub, 0x12 mul, 0x13 div, 0xFF halt. Load-to-stack and store-from-stack are followed by a 3-byte address, most significant byte first. The program counter advances by 4 for those two and by 1 for the others.
- R3: Load-to-stack A reads bytes A..A+3 as one big-endian word and places it on top of the stack.
- R4: Store-from-stack A writes the top entry to bytes A..A+3, most significant byte at A, and removes it from the stack.
- R5: Arithmetic computes (second entry) op (top entry). The result replaces both operands. Add, sub and mul wrap modulo 2^32. Div is an unsigned truncating quotient.
- R6: The stack is last-in first-out and holds 16 words without loss.
- R7: Opcode 0xFF halts with `fault` low, and the core makes no further memory access. Instructions placed after it are not executed.
- R8: The following raise `fault` and halt, and the offending instruction writes nothing to memory: a load onto a full stack, a store with an empty stack, arithmetic with fewer than two entries, division by zero, or any unlisted opcode.
- R9: `fault` and `halted` stay high until reset.
- R10: Read data on `mem_rdata` is taken one cycle after a request. `mem_we` is only ever raised together with `mem_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | Memory access request this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 24 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid the cycle after a read request |
| halted | output | 1 | Core has stopped |
| fault | output | 1 | Sticky illegal-condition flag |

## Verification
An expression program that mixes both instruction lengths checks operand order and program counter stepping together, since a wrong step or a swapped operand gives a different final value. Separate programs with operands chosen so that order matters (small minus large, a non-exact quotient, a product that overflows) tell sub, div and mul apart from commutative or widened results. Filling the stack to exactly 16 and draining it checks LIFO order and capacity, and a 17th load shows that the full limit is enforced. Each fault cause is triggered alone, and the memory write count confirms that nothing was stored.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam logic [7:0] OP_LOAD  = 8'h01;
  localparam logic [7:0] OP_STORE = 8'h02;
  localparam logic [7:0] OP_ADD   = 8'h10;
  localparam logic [7:0] OP_SUB   = 8'h11;
  localparam logic [7:0] OP_MUL   = 8'h12;
  localparam logic [7:0] OP_DIV   = 8'h13;
  localparam logic [7:0] OP_HALT  = 8'hFF;

  typedef enum logic [2:0] {
    S_FETCH, S_DECODE, S_ADR_REQ, S_ADR_CAP,
    S_DAT_REQ, S_DAT_CAP, S_WRITE, S_STOP
  } core_state_e;

  typedef enum logic [1:0] {
    STK_NONE, STK_PUSH, STK_POP, STK_MERGE
  } stk_op_e;

  typedef enum logic [1:0] {
    ALU_ADD, ALU_SUB, ALU_MUL, ALU_DIV
  } alu_op_e;
endpackage

// File: rtl/stk_alu.sv
module stk_alu
  import stk_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_op_e             op,
  input  logic [DATA_W-1:0]   lhs,
  input  logic [DATA_W-1:0]   rhs,
  output logic [DATA_W-1:0]   res
);
  always_comb begin
    unique case (op)
      ALU_ADD: res = lhs + rhs;
      ALU_SUB: res = lhs - rhs;
      ALU_MUL: res = lhs * rhs;
      default: res = (rhs == '0) ? '0 : lhs / rhs;
    endcase
  end
endmodule

// File: rtl/stk_opstack.sv
module stk_opstack
  import stk_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  stk_op_e           op,
  input  logic [DATA_W-1:0] wval,
  output logic [DATA_W-1:0] top,
  output logic [DATA_W-1:0] second,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic              full
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);

  logic [DATA_W-1:0] ent [DEPTH];
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [IW-1:0]     top_idx, sec_idx, new_idx;

  assign new_idx = IW'(cnt_q);
  assign top_idx = IW'(cnt_q - CW'(1));
  assign sec_idx = IW'(cnt_q - CW'(2));
  assign top     = (cnt_q >= CW'(1)) ? ent[top_idx] : '0;
  assign second  = (cnt_q >= CW'(2)) ? ent[sec_idx] : '0;
  assign count   = cnt_q;
  assign full    = (cnt_q == CW'(DEPTH));

  always_comb begin
    unique case (op)
      STK_PUSH:  cnt_d = cnt_q + CW'(1);
      STK_POP,
      STK_MERGE: cnt_d = cnt_q - CW'(1);
      default:   cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (op == STK_PUSH)       ent[new_idx] <= wval;
    else if (op == STK_MERGE) ent[sec_idx] <= wval;
  end
endmodule

// File: rtl/stk_core.sv
module stk_core
  import stk_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              halted,
  output logic              fault
);
  localparam int WBYTES = DATA_W / 8;
  localparam int ABYTES = ADDR_W / 8;
  localparam int BC_W   = $clog2(WBYTES);
  localparam int CW     = $clog2(DEPTH + 1);

  logic [1:0]        rst_sync;
  logic              rst_ns;
  core_state_e       st_q, st_d;
  logic [ADDR_W-1:0] pc_q, pc_d, adr_q, adr_d;
  logic [DATA_W-1:0] dat_q, dat_d, word_in, alu_res, tos, sos, push_val;
  logic [BC_W-1:0]   bc_q, bc_d;
  logic [7:0]        opc_q, opc_d;
  logic              flt_q, flt_d;
  stk_op_e           sop;
  logic [CW-1:0]     stk_cnt;
  logic              stk_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ns = rst_sync[1];

  stk_opstack #(.DATA_W(DATA_W), .DEPTH(DEPTH)) stack_i (
    .clk(clk), .rst_n(rst_ns), .op(sop), .wval(push_val),
    .top(tos), .second(sos), .count(stk_cnt), .full(stk_full)
  );

  stk_alu #(.DATA_W(DATA_W)) alu_i (
    .op(alu_op_e'(mem_rdata[1:0])), .lhs(sos), .rhs(tos), .res(alu_res)
  );

  assign word_in = {dat_q[DATA_W-9:0], mem_rdata};

  always_comb begin
    st_d = st_q; pc_d = pc_q; adr_d = adr_q; dat_d = dat_q;
    bc_d = bc_q; opc_d = opc_q; flt_d = flt_q;
    sop = STK_NONE; push_val = alu_res;
    mem_req = 1'b0; mem_we = 1'b0; mem_addr = pc_q; mem_wdata = '0;
    unique case (st_q)
      S_FETCH: begin
        mem_req = 1'b1;
        pc_d    = pc_q + ADDR_W'(1);
        st_d    = S_DECODE;
      end
      S_DECODE: begin
        opc_d = mem_rdata;
        bc_d  = '0;
        unique case (mem_rdata)
          OP_LOAD:  if (stk_full) begin flt_d = 1'b1; st_d = S_STOP; end
                    else st_d = S_ADR_REQ;
          OP_STORE: if (stk_cnt == '0) begin flt_d = 1'b1; st_d = S_STOP; end
                    else st_d = S_ADR_REQ;
          OP_ADD, OP_SUB, OP_MUL, OP_DIV:
            if (stk_cnt < CW'(2) || (mem_rdata == OP_DIV && tos == '0)) begin
              flt_d = 1'b1; st_d = S_STOP;
            end else begin
              sop = STK_MERGE; st_d = S_FETCH;
            end
          OP_HALT:  st_d = S_STOP;
          default:  begin flt_d = 1'b1; st_d = S_STOP; end
        endcase
      end
      S_ADR_REQ: begin
        mem_req = 1'b1;
        pc_d    = pc_q + ADDR_W'(1);
        st_d    = S_ADR_CAP;
      end
      S_ADR_CAP: begin
        adr_d = {adr_q[ADDR_W-9:0], mem_rdata};
        if (bc_q == BC_W'(ABYTES - 1)) begin
          bc_d = '0;
          st_d = (opc_q == OP_LOAD) ? S_DAT_REQ : S_WRITE;
        end else begin
          bc_d = bc_q + BC_W'(1);
          st_d = S_ADR_REQ;
        end
      end
      S_DAT_REQ: begin
        mem_req  = 1'b1;
        mem_addr = adr_q + ADDR_W'(bc_q);
        st_d     = S_DAT_CAP;
      end
      S_DAT_CAP: begin
        dat_d = word_in;
        if (bc_q == BC_W'(WBYTES - 1)) begin
          sop = STK_PUSH; push_val = word_in; st_d = S_FETCH;
        end else begin
          bc_d = bc_q + BC_W'(1); st_d = S_DAT_REQ;
        end
      end
      S_WRITE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = adr_q + ADDR_W'(bc_q);
        mem_wdata = 8'(tos >> (8 * (WBYTES - 1 - int'(bc_q))));
        if (bc_q == BC_W'(WBYTES - 1)) begin
          sop = STK_POP; st_d = S_FETCH;
        end else begin
          bc_d = bc_q + BC_W'(1);
        end
      end
      default: st_d = S_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q <= S_FETCH; pc_q <= '0; adr_q <= '0; dat_q <= '0;
      bc_q <= '0; opc_q <= '0; flt_q <= 1'b0;
    end else begin
      st_q <= st_d; pc_q <= pc_d; adr_q <= adr_d; dat_q <= dat_d;
      bc_q <= bc_d; opc_q <= opc_d; flt_q <= flt_d;
    end
  end

  assign halted = (st_q == S_STOP);
  assign fault  = flt_q;
endmodule

// File: rtl/stk_core_chk.sv
module stk_core_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       mem_req,
  input logic                       mem_we,
  input logic                       halted,
  input logic                       fault,
  input logic [$clog2(DEPTH+1)-1:0] depth
);
  a_r7_quiet_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_req);
  a_r9_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);
  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  a_r8_fault_halts: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> halted);
  a_r10_write_is_access: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);
  a_r6_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= ($clog2(DEPTH+1))'(DEPTH));
  a_r8_fault_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> !mem_we);
endmodule

bind stk_core stk_core_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .halted(halted), .fault(fault), .depth(stk_cnt)
);

// File: tb/stk_core_tb_top.sv
module stk_core_tb_top;
  logic        clk;
  logic        rst_n;
  logic        mem_req, mem_we, halted, fault;
  logic [23:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [7:0]  mem [1024];
  int          wr_count;
  int          n_chk, n_bad, ppc, cyc_total;

  stk_core dut_i (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .halted(halted), .fault(fault)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) wr_count <= 0;
    else if (mem_req) begin
      if (mem_we) begin
        mem[mem_addr[9:0]] <= mem_wdata;
        wr_count <= wr_count + 1;
      end else begin
        mem_rdata <= mem[mem_addr[9:0]];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic begin_prog();
    rst_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    ppc = 0;
  endtask

  task automatic emit(input logic [7:0] op);
    mem[ppc] = op; ppc++;
  endtask

  task automatic emit_a(input logic [7:0] op, input int a);
    mem[ppc] = op; mem[ppc+1] = 8'(a >> 16);
    mem[ppc+2] = 8'(a >> 8); mem[ppc+3] = 8'(a); ppc += 4;
  endtask

  task automatic put_word(input int a, input logic [31:0] v);
    for (int i = 0; i < 4; i++) mem[a+i] = 8'(v >> (24 - 8*i));
  endtask

  function automatic logic [31:0] get_word(input int a);
    return {mem[a], mem[a+1], mem[a+2], mem[a+3]};
  endfunction

  task automatic run_prog(input string tag);
    int c;
    @(negedge clk);
    rst_n = 1'b1;
    c = 0;
    while (!halted && c < 5000) begin
      @(negedge clk); c++;
    end
    chk(halted, {tag, " halt reached"}, halted, 1);
  endtask

  task automatic t_reset();
    begin_prog();
    repeat (3) @(negedge clk);
    chk(mem_addr == 24'h0, "R1 first fetch address", mem_addr, 0);
    chk(!mem_we, "R1 no write in reset", mem_we, 0);
    chk(!fault && !halted, "R1 flags clear", {fault, halted}, 0);
  endtask

  task automatic t_expr();
    begin_prog();
    put_word(512, 7); put_word(516, 5); put_word(520, 3);
    emit_a(8'h01, 512); emit_a(8'h01, 516); emit(8'h12);
    emit_a(8'h01, 512); emit_a(8'h01, 520); emit_a(8'h01, 516);
    emit(8'h12); emit(8'h10); emit(8'h11);
    emit_a(8'h02, 600); emit(8'hFF);
    run_prog("R2");
    chk(get_word(600) == 32'd13, "R2 R3 R5 expression result", get_word(600), 13);
    chk(mem[600] == 8'h00 && mem[603] == 8'd13, "R4 big-endian byte order",
        {mem[600], mem[603]}, 16'h000D);
    chk(!fault, "R7 clean halt", fault, 0);
  endtask

  task automatic t_order();
    begin_prog();
    put_word(512, 3); put_word(516, 10); put_word(520, 100); put_word(524, 7);
    put_word(528, 32'h12345678); put_word(532, 32'h10);
    emit_a(8'h01, 512); emit_a(8'h01, 516); emit(8'h11); emit_a(8'h02, 600);
    emit_a(8'h01, 520); emit_a(8'h01, 524); emit(8'h13); emit_a(8'h02, 604);
    emit_a(8'h01, 528); emit_a(8'h01, 532); emit(8'h12); emit_a(8'h02, 608);
    emit(8'hFF);
    run_prog("R5");
    chk(get_word(600) == 32'hFFFFFFF9, "R5 sub wraps second minus top",
        get_word(600), 32'hFFFFFFF9);
    chk(get_word(604) == 32'd14, "R5 div truncates", get_word(604), 14);
    chk(get_word(608) == 32'h23456780, "R5 mul low word", get_word(608), 32'h23456780);
  endtask

  task automatic t_depth();
    begin_prog();
    for (int i = 0; i < 16; i++) put_word(512 + 4*i, 32'hA000 + i);
    for (int i = 0; i < 16; i++) emit_a(8'h01, 512 + 4*i);
    for (int i = 0; i < 16; i++) emit_a(8'h02, 640 + 4*i);
    emit(8'hFF);
    run_prog("R6");
    chk(!fault, "R6 sixteen entries accepted", fault, 0);
    for (int k = 0; k < 16; k++)
      chk(get_word(640 + 4*k) == 32'hA000 + 15 - k, "R6 LIFO order",
          get_word(640 + 4*k), 32'hA000 + 15 - k);
  endtask

  task automatic t_overflow();
    begin_prog();
    for (int i = 0; i < 17; i++) emit_a(8'h01, 512);
    emit_a(8'h02, 700); emit(8'hFF);
    run_prog("R8");
    chk(fault, "R8 load onto full stack", fault, 1);
    chk(wr_count == 0, "R8 overflow writes nothing", wr_count, 0);
  endtask

  task automatic t_underflow();
    begin_prog();
    emit_a(8'h02, 700); emit(8'hFF);
    run_prog("R8");
    chk(fault, "R8 store with empty stack", fault, 1);
    chk(wr_count == 0, "R8 empty store writes nothing", wr_count, 0);
    begin_prog();
    put_word(512, 9);
    emit_a(8'h01, 512); emit(8'h10); emit_a(8'h02, 700); emit(8'hFF);
    run_prog("R8");
    chk(fault, "R8 add with one entry", fault, 1);
    chk(wr_count == 0, "R8 short add writes nothing", wr_count, 0);
  endtask

  task automatic t_divzero();
    begin_prog();
    put_word(512, 8);
    emit_a(8'h01, 512); emit_a(8'h01, 516); emit(8'h13);
    emit_a(8'h02, 700); emit(8'hFF);
    run_prog("R8");
    chk(fault, "R8 divide by zero", fault, 1);
    chk(wr_count == 0, "R8 div zero writes nothing", wr_count, 0);
  endtask

  task automatic t_badop();
    begin_prog();
    put_word(512, 4);
    emit_a(8'h01, 512); emit(8'h55); emit_a(8'h02, 700);
    run_prog("R8");
    chk(fault, "R8 unknown opcode", fault, 1);
    repeat (10) @(negedge clk);
    chk(fault && halted, "R9 flags sticky", {fault, halted}, 3);
    chk(wr_count == 0, "R8 unknown opcode writes nothing", wr_count, 0);
  endtask

  task automatic t_halt();
    begin_prog();
    put_word(512, 32'hCAFE);
    emit_a(8'h01, 512); emit(8'hFF); emit_a(8'h02, 700);
    run_prog("R7");
    chk(!fault, "R7 halt without fault", fault, 0);
    for (int i = 0; i < 5; i++) begin
      chk(!mem_req, "R7 no access after halt", mem_req, 0);
      @(negedge clk);
    end
    chk(get_word(700) == 0 && wr_count == 0, "R7 following store skipped",
        get_word(700), 0);
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0;
    mem_rdata = 8'h00;
    t_reset();
    t_expr();
    t_order();
    t_depth();
    t_overflow();
    t_underflow();
    t_divzero();
    t_badop();
    t_halt();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc_total = 0;
    while (cyc_total < 150000) begin
      @(posedge clk); cyc_total++;
    end
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc_total);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule